// File: doc/BRIEF.md
# Dominant Timeout and Fault Reporter

This block watches the transmit side of a single-wire, open-drain serial bus transceiver. It keeps two independent timers, one on the controller's transmit data and one on the level read back from the bus. Either timer gates off the dominant drive when it sees a dominant level that lasts too long. After every transmit-data edge it waits a fixed number of microsecond ticks and then compares the transmit level with the received level. This delay lets the bus settle past its propagation and slope times before the comparison is made. It also turns a thermal-shutdown indication into an immediate loss of drive. All of these causes are merged into one registered, active-low fault flag that is also presented as a pull-down enable for an open-drain fault pin.

Time is measured in ticks of an external one-microsecond strobe. The two timeout lengths and the sampling delay are parameters in ticks. The analog driver, the temperature sensor and the power-mode sequencing sit outside the block. A two-stage synchronizer releases the asynchronous reset on a clock edge.

Top module: `dom_fault_supervisor`

## Requirements
- R1: After transmit data has been sampled low on TXD_LIMIT ticks in a row, the transmitter is disabled (`tx_en_o` low, `drv_dom_o` low) from the clock edge that counts the last tick, and one edge later the fault flag asserts.
- R2: A transmit-data timeout is held while transmit data stays low, and it is released on the first clock edge at which transmit data is high. That edge re-enables the transmitter.
- R3: After the bus has read dominant (`rxd_i` = 0) on BUS_LIMIT ticks in a row, the transmitter is disabled and one edge later the fault flag asserts. Any recessive reading restarts the count from zero.
- R4: A bus timeout is released only on an edge where the bus is recessive and chip-select (`cs_i`) is high. While chip-select is low it stays held, even on a recessive bus.
- R5: Both timers advance only on edges where `tick_i` is 1, and both saturate at their limit, so a dominant level held indefinitely never re-enables the transmitter.
- R6: Each change of transmit data starts a delay of SAMPLE_DLY ticks, and a further edge restarts it. When the delay expires, the contention result is set if transmit and receive levels differ and cleared if they match. The flag follows one edge later.
- R7: Between samples the contention result holds its last value, whatever the received level does.
- R8: While `thermal_i` is 1 the transmitter is disabled at once. The fault flag asserts on the next edge and releases on the edge after the thermal flag drops, provided no other cause is active.
- R9: `fault_n_o` is low (0 = fault) when any cause was present on the previous edge, and `fault_pd_o` is its complement, so 1 means the pin is pulled low.
- R10: `drv_dom_o` is 1 only when transmit data is low and the transmitter is enabled, and it is 0 whenever transmit data is high.
- R11: Out of reset, with inputs recessive and no thermal flag, `fault_n_o` = 1, `fault_pd_o` = 0, `tx_en_o` = 1 and `drv_dom_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe per microsecond |
| txd_i | input | 1 | Transmit data from controller, 0 = dominant |
| rxd_i | input | 1 | Received bus level, 0 = dominant |
| cs_i | input | 1 | Chip-select, needed high to release a bus timeout |
| thermal_i | input | 1 | Thermal shutdown active |
| tx_en_o | output | 1 | Transmitter enabled |
| drv_dom_o | output | 1 | Drive the bus dominant |
| fault_n_o | output | 1 | Fault flag to controller, active low |
| fault_pd_o | output | 1 | Pull-down enable of the open-drain fault pin |

## Verification
The hardest case to reach is the one where the contention sampler must restart on a second transmit edge. A mismatch is latched first. A short low pulse on transmit data is then followed by its rising edge, so that the sample belonging to the falling edge would have cleared the flag one edge early. The bench checks the flag on exactly that edge to tell a restart from a missing one. The receive line is modelled as a wired-AND of the block's own drive and a bench-controlled external dominant, so bus contention and external bus shorts come about naturally from the ports.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

  typedef struct packed {
    logic txd_to;
    logic bus_to;
    logic contention;
    logic thermal;
  } dfs_cause_t;

  function automatic logic dfs_any(input dfs_cause_t c);
    return c.txd_to | c.bus_to | c.contention | c.thermal;
  endfunction

endpackage

// File: rtl/dfs_rst_sync.sv
module dfs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/dfs_dom_timer.sv
module dfs_dom_timer #(
  parameter int LIMIT = 25000,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          dom_i,
  input  logic          release_i,
  output logic          to_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          to_q, to_d;
  logic          at_limit, last_tick;

  assign at_limit  = (cnt_q == CW'(LIMIT));
  assign last_tick = dom_i & tick_i & (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!dom_i)                    cnt_d = '0;
    else if (tick_i && !at_limit)  cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    to_d = to_q;
    if (release_i)      to_d = 1'b0;
    else if (last_tick) to_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      to_q  <= to_d;
    end
  end

  assign to_o  = to_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/dfs_edge_sampler.sv
module dfs_edge_sampler #(
  parameter int DLY  = 30,
  localparam int CW  = $clog2(DLY + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic txd_i,
  input  logic rxd_i,
  output logic mismatch_o
);
  logic          prev_q, prev_d;
  logic          armed_q, armed_d;
  logic [CW-1:0] dly_q, dly_d;
  logic          mis_q, mis_d;
  logic          edge_seen, expire;

  assign edge_seen = txd_i ^ prev_q;
  assign expire    = armed_q & tick_i & (dly_q == CW'(DLY - 1));

  always_comb begin
    prev_d  = txd_i;
    armed_d = armed_q;
    dly_d   = dly_q;
    mis_d   = mis_q;
    if (edge_seen) begin
      armed_d = 1'b1;
      dly_d   = '0;
    end else if (expire) begin
      armed_d = 1'b0;
      dly_d   = '0;
      mis_d   = txd_i ^ rxd_i;
    end else if (armed_q && tick_i) begin
      dly_d   = dly_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b1;
      armed_q <= 1'b0;
      dly_q   <= '0;
      mis_q   <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      armed_q <= armed_d;
      dly_q   <= dly_d;
      mis_q   <= mis_d;
    end
  end

  assign mismatch_o = mis_q;
endmodule

// File: rtl/dom_fault_supervisor.sv
module dom_fault_supervisor
  import dfs_pkg::*;
#(
  parameter int TXD_LIMIT   = 25000,
  parameter int BUS_LIMIT   = 25000,
  parameter int SAMPLE_DLY  = 30,
  parameter int SYNC_STAGES = 2,
  localparam int TXD_CW     = $clog2(TXD_LIMIT + 1),
  localparam int BUS_CW     = $clog2(BUS_LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic txd_i,
  input  logic rxd_i,
  input  logic cs_i,
  input  logic thermal_i,
  output logic tx_en_o,
  output logic drv_dom_o,
  output logic fault_n_o,
  output logic fault_pd_o
);
  logic              rst_sync_n;
  logic              txd_to, bus_to, mismatch;
  logic [TXD_CW-1:0] txd_cnt;
  logic [BUS_CW-1:0] bus_cnt;
  dfs_cause_t        cause;
  logic              flt_q, flt_d;

  dfs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  dfs_dom_timer #(.LIMIT(TXD_LIMIT)) u_txd_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .tick_i    (tick_i),
    .dom_i     (~txd_i),
    .release_i (txd_i),
    .to_o      (txd_to),
    .cnt_o     (txd_cnt)
  );

  dfs_dom_timer #(.LIMIT(BUS_LIMIT)) u_bus_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .tick_i    (tick_i),
    .dom_i     (~rxd_i),
    .release_i (rxd_i & cs_i),
    .to_o      (bus_to),
    .cnt_o     (bus_cnt)
  );

  dfs_edge_sampler #(.DLY(SAMPLE_DLY)) u_smp (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .tick_i     (tick_i),
    .txd_i      (txd_i),
    .rxd_i      (rxd_i),
    .mismatch_o (mismatch)
  );

  always_comb begin
    cause.txd_to     = txd_to;
    cause.bus_to     = bus_to;
    cause.contention = mismatch;
    cause.thermal    = thermal_i;
    flt_d            = dfs_any(cause);
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) flt_q <= 1'b0;
    else             flt_q <= flt_d;
  end

  assign tx_en_o    = ~(txd_to | bus_to | thermal_i);
  assign drv_dom_o  = tx_en_o & ~txd_i;
  assign fault_n_o  = ~flt_q;
  assign fault_pd_o = flt_q;
endmodule

// File: rtl/dfs_checker.sv
module dfs_checker #(
  parameter int TXD_LIMIT = 25000,
  parameter int BUS_LIMIT = 25000,
  localparam int TXD_CW   = $clog2(TXD_LIMIT + 1),
  localparam int BUS_CW   = $clog2(BUS_LIMIT + 1)
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              tick_i,
  input logic              txd_i,
  input logic              rxd_i,
  input logic              cs_i,
  input logic              thermal_i,
  input logic              drv_dom_o,
  input logic              fault_n_o,
  input logic              txd_to,
  input logic              bus_to,
  input logic [TXD_CW-1:0] txd_cnt,
  input logic [BUS_CW-1:0] bus_cnt
);
  p_txd_timeout_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!txd_i && tick_i && txd_cnt == TXD_CW'(TXD_LIMIT - 1)) |=> txd_to);

  p_timeout_faults_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    txd_to |=> !fault_n_o);

  p_txd_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (txd_to && !txd_i) |=> txd_to);

  p_bus_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_to && !(rxd_i && cs_i)) |=> bus_to);

  p_txd_sat_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    txd_cnt <= TXD_CW'(TXD_LIMIT));

  p_bus_sat_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    bus_cnt <= BUS_CW'(BUS_LIMIT));

  p_no_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!tick_i && !txd_i) |=> txd_cnt == $past(txd_cnt));

  p_thermal_fault_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    thermal_i |=> !fault_n_o);

  p_thermal_nodrive_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    thermal_i |-> !drv_dom_o);

  p_clear_after_thermal_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(fault_n_o) |-> !$past(thermal_i));

  p_recessive_nodrive_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    txd_i |-> !drv_dom_o);
endmodule

bind dom_fault_supervisor dfs_checker #(
  .TXD_LIMIT (TXD_LIMIT),
  .BUS_LIMIT (BUS_LIMIT)
) u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_sync_n),
  .tick_i    (tick_i),
  .txd_i     (txd_i),
  .rxd_i     (rxd_i),
  .cs_i      (cs_i),
  .thermal_i (thermal_i),
  .drv_dom_o (drv_dom_o),
  .fault_n_o (fault_n_o),
  .txd_to    (txd_to),
  .bus_to    (bus_to),
  .txd_cnt   (txd_cnt),
  .bus_cnt   (bus_cnt)
);

// File: tb/dom_fault_supervisor_tb.sv
`timescale 1ns/1ps
module dom_fault_supervisor_tb;
  localparam int TL = 6;
  localparam int BL = 9;
  localparam int SD = 3;

  logic clk = 1'b0;
  logic rst_n, tick, txd, cs, thermal, ext_dom;
  logic rxd;
  logic tx_en, drv_dom, fault_n, fault_pd;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  assign rxd = ~(drv_dom | ext_dom);

  dom_fault_supervisor #(
    .TXD_LIMIT (TL),
    .BUS_LIMIT (BL),
    .SAMPLE_DLY(SD)
  ) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .txd_i     (txd),
    .rxd_i     (rxd),
    .cs_i      (cs),
    .thermal_i (thermal),
    .tx_en_o   (tx_en),
    .drv_dom_o (drv_dom),
    .fault_n_o (fault_n),
    .fault_pd_o(fault_pd)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 1'b1; txd = 1'b1; cs = 1'b1; thermal = 1'b0; ext_dom = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    // R11 reset state
    check("R11", "fault_n", fault_n, 1'b1);
    check("R11", "fault_pd", fault_pd, 1'b0);
    check("R11", "tx_en", tx_en, 1'b1);
    check("R11", "drv_dom", drv_dom, 1'b0);

    // R1 / R2: sweep the length of a low transmit level
    for (int n = 1; n <= TL + 3; n++) begin
      txd = 1'b0;
      cyc(n);
      check("R1", "drv_dom", drv_dom, (n < TL) ? 1'b1 : 1'b0);
      check("R1", "fault_n", fault_n, (n >= TL + 1) ? 1'b0 : 1'b1);
      check("R9", "fault_pd", fault_pd, (n >= TL + 1) ? 1'b1 : 1'b0);
      txd = 1'b1;
      cyc(1);
      check("R2", "tx_en", tx_en, 1'b1);
      cyc(SD + 1);
      check("R2", "fault_n", fault_n, 1'b1);
    end

    // R3: sweep external dominant length with transmit recessive
    for (int n = 1; n <= BL + 2; n++) begin
      ext_dom = 1'b1;
      cyc(n);
      check("R3", "tx_en", tx_en, (n < BL) ? 1'b1 : 1'b0);
      check("R3", "fault_n", fault_n, (n >= BL + 1) ? 1'b0 : 1'b1);
      check("R10", "drv_dom", drv_dom, 1'b0);
      ext_dom = 1'b0;
      cyc(2);
      check("R3", "tx_en rel", tx_en, 1'b1);
      check("R3", "fault_n rel", fault_n, 1'b1);
    end

    // R3: a single recessive reading restarts the bus count
    ext_dom = 1'b1; cyc(BL - 1);
    ext_dom = 1'b0; cyc(1);
    ext_dom = 1'b1; cyc(BL - 1);
    check("R3", "tx_en restart", tx_en, 1'b1);
    ext_dom = 1'b0; cyc(2);

    // R4: release needs chip-select high
    ext_dom = 1'b1; cyc(BL + 1);
    cs = 1'b0; ext_dom = 1'b0;
    cyc(4);
    check("R4", "tx_en cs low", tx_en, 1'b0);
    check("R4", "fault_n cs low", fault_n, 1'b0);
    cs = 1'b1;
    cyc(1);
    check("R4", "tx_en cs high", tx_en, 1'b1);
    cyc(1);
    check("R4", "fault_n cs high", fault_n, 1'b1);

    // R5: no tick, no timing; saturation holds the timeout
    tick = 1'b0; txd = 1'b0;
    cyc(50);
    check("R5", "drv_dom no tick", drv_dom, 1'b1);
    check("R10", "drv_dom low txd", drv_dom, 1'b1);
    check("R5", "fault_n no tick", fault_n, 1'b1);
    tick = 1'b1;
    cyc(TL);
    check("R5", "drv_dom ticked", drv_dom, 1'b0);
    cyc(200);
    check("R5", "drv_dom saturated", drv_dom, 1'b0);
    check("R5", "fault_n saturated", fault_n, 1'b0);
    txd = 1'b1;
    cyc(SD + 3);
    check("R2", "fault_n after long", fault_n, 1'b1);
    check("R2", "tx_en after long", tx_en, 1'b1);

    // R6: contention after a rising edge against a held bus
    txd = 1'b0; cyc(2);
    ext_dom = 1'b1; txd = 1'b1;
    cyc(SD + 1);
    check("R6", "fault_n before sample", fault_n, 1'b1);
    cyc(1);
    check("R6", "fault_n after sample", fault_n, 1'b0);
    // R7: bus released, no transmit edge, result holds
    ext_dom = 1'b0;
    cyc(6);
    check("R7", "fault_n held", fault_n, 1'b0);
    // R6: the second edge restarts the delay
    txd = 1'b0; cyc(1);
    txd = 1'b1;
    cyc(SD + 1);
    check("R6", "fault_n restart", fault_n, 1'b0);
    cyc(1);
    check("R6", "fault_n cleared", fault_n, 1'b1);

    // R8 / R10: thermal shutdown
    thermal = 1'b1;
    #1;
    check("R8", "tx_en thermal", tx_en, 1'b0);
    cyc(1);
    check("R8", "fault_n thermal", fault_n, 1'b0);
    check("R9", "fault_pd thermal", fault_pd, 1'b1);
    txd = 1'b0;
    #1;
    check("R10", "drv_dom thermal", drv_dom, 1'b0);
    cyc(1);
    txd = 1'b1;
    cyc(1);
    thermal = 1'b0;
    #1;
    check("R8", "tx_en after thermal", tx_en, 1'b1);
    cyc(1);
    check("R8", "fault_n after thermal", fault_n, 1'b1);
    cyc(SD + 2);
    check("R8", "fault_n settled", fault_n, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    done = 1'b1;
    $finish;
  end
endmodule